// File: doc/BRIEF.md
# Change-Detection Interrupt Controller

This block watches a bank of digital input channels and raises a level interrupt when a selected transition occurs. Each monitored channel has its own rising enable bit and its own falling enable bit. A control register turns each of the two direction classes on or off and gates the interrupt sources. Each input passes through a two-flop synchronizer. A transition is then found by comparing the synchronized value with the value one clock earlier.

An edge flag latches the first qualifying transition. A second qualifying transition that arrives while the edge flag is still set latches an overflow flag. Software reads a status byte and acknowledges through a write-one-to-clear register, in which the edge and overflow flags are cleared by separate bits. All registers are one byte wide and sit behind a simple synchronous write and combinational read interface. Only the lower byte lanes carry enable masks. The remaining input channels can be read but are never monitored.

Register map (5-bit address):

| Address | Register |
|---|---|
| 0x00 + lane | synchronized input byte |
| 0x08 | status |
| 0x09 | control |
| 0x0A | clear |
| 0x10 + lane | rising mask |
| 0x18 + lane | falling mask |

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the rising masks, falling masks, control register, edge flag and overflow flag are all zero, `irqOut` is low and the status register reads 0x00.
- R2: The rising mask lanes at 0x10 and 0x11 and the falling mask lanes at 0x18 and 0x19 store the written byte and read it back unchanged. Bit n of lane L controls channel 8L+n.
- R3: Mask addresses for lanes at or above MON_CHAN/8 (0x12 and 0x1A by default) read as 0x00 and ignore writes. Transitions on channels 16 to 23 never set the edge flag.
- R4: A 0-to-1 change on a channel whose rising mask bit is set, with control bit 3 set, sets status bit 0. The flag is visible after the third rising clock edge following the input change. A 1-to-0 change on that channel does not set the flag unless its falling mask bit is set.
- R5: A 1-to-0 change on a channel whose falling mask bit is set, with control bit 4 set, sets status bit 0 with the same latency as in R4.
- R6: With control bit 3 clear, rising transitions set no flag, even on channels whose rising mask bit is set.
- R7: A qualifying transition that occurs while the edge flag is already set sets the overflow flag, which is status bit 1.
- R8: Writing the clear register at 0x0A with bit 3 set clears the edge flag, and with bit 2 set clears the overflow flag. The two bits act independently, and the other bits have no effect.
- R9: `irqOut` is high exactly when control bit 2 is set and either the edge flag with control bit 0, or the overflow flag with control bit 1, is set. Status bit 2 always equals `irqOut`.
- R10: Addresses 0x00 to 0x02 return the synchronized input bytes. Channel 8L+n appears at bit n of address L.
- R11: The control register at 0x09 reads back bits 4 to 0 as written, and its bits 7 to 5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanIn | input | NUM_CHAN | Asynchronous digital input channels |
| regAddr | input | ADDR_W | Register byte address |
| regWrEn | input | 1 | Write strobe, one byte per cycle |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: 24 input channels, of which 16 are monitored, and a 5-bit address. With these values the third byte lane exists for input readback but has no masks, so the ignored mask addresses and the unmonitored upper channels can be observed at the ports. The test scenarios cover several patterns: a single channel in each direction, the direction-class gating, a second edge that causes overflow, independent acknowledgement of each flag, and every combination of interrupt gating that changes the output.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int LANE_BITS = 3;

  // status bit positions
  localparam int ST_IRQ  = 2;
  localparam int ST_OVF  = 1;
  localparam int ST_EDGE = 0;
  // control bit positions
  localparam int CT_FALL = 4;
  localparam int CT_RISE = 3;
  localparam int CT_IRQ  = 2;
  localparam int CT_OVF  = 1;
  localparam int CT_EDGE = 0;
  localparam int CTRL_W  = 5;
  // clear bit positions
  localparam int CL_EDGE = 3;
  localparam int CL_OVF  = 2;

  typedef enum logic [2:0] {
    RD_NONE, RD_IN, RD_STAT, RD_CTRL, RD_RISE, RD_FALL
  } rdSel_e;

  typedef struct packed {
    logic                 riseWr;
    logic                 fallWr;
    logic                 ctrlWr;
    logic                 clrWr;
    logic [LANE_BITS-1:0] lane;
    rdSel_e               rdSel;
  } regStrobe_t;
endpackage

// File: rtl/edge_irq_decode.sv
module edge_irq_decode
  import edge_irq_pkg::*;
#(
  parameter int NUM_CHAN = 24,
  parameter int MON_CHAN = 16,
  parameter int ADDR_W   = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strb
);
  localparam int IN_LANES  = (NUM_CHAN + 7) / 8;
  localparam int MON_LANES = (MON_CHAN + 7) / 8;

  logic [1:0]           region;
  logic [LANE_BITS-1:0] idx;
  logic                 hiZero;

  assign region = regAddr[4:3];
  assign idx    = regAddr[2:0];
  assign hiZero = (regAddr >> 5) == '0;

  always_comb begin
    strb       = '0;
    strb.lane  = idx;
    strb.rdSel = RD_NONE;
    if (hiZero) begin
      unique case (region)
        2'd0: if (int'(idx) < IN_LANES) strb.rdSel = RD_IN;
        2'd1: begin
          if (idx == 3'd0) strb.rdSel = RD_STAT;
          if (idx == 3'd1) begin
            strb.rdSel  = RD_CTRL;
            strb.ctrlWr = regWrEn;
          end
          if (idx == 3'd2) strb.clrWr = regWrEn;
        end
        2'd2: if (int'(idx) < MON_LANES) begin
          strb.rdSel  = RD_RISE;
          strb.riseWr = regWrEn;
        end
        default: if (int'(idx) < MON_LANES) begin
          strb.rdSel  = RD_FALL;
          strb.fallWr = regWrEn;
        end
      endcase
    end
  end
endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int NUM_CHAN = 24,
  parameter int MON_CHAN = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CHAN-1:0] chanIn,
  input  regStrobe_t          strb,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  output logic                irqOut
);
  localparam int IN_LANES  = (NUM_CHAN + 7) / 8;
  localparam int MON_LANES = (MON_CHAN + 7) / 8;

  logic [NUM_CHAN-1:0]    sync1, sync2;
  logic [MON_CHAN-1:0]    prevIn;
  logic [MON_LANES*8-1:0] riseMask, fallMask;
  logic [CTRL_W-1:0]      ctrlReg;
  logic                   edgeFlag, ovfFlag;
  logic [MON_CHAN-1:0]    riseHit, fallHit;
  logic                   anyEdge, clrEdge, clrOvf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1  <= '0;
      sync2  <= '0;
      prevIn <= '0;
    end else begin
      sync1  <= chanIn;
      sync2  <= sync1;
      prevIn <= sync2[MON_CHAN-1:0];
    end
  end

  for (genvar g = 0; g < MON_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        riseMask[g*8 +: 8] <= '0;
        fallMask[g*8 +: 8] <= '0;
      end else begin
        if (strb.riseWr && int'(strb.lane) == g) riseMask[g*8 +: 8] <= wrData;
        if (strb.fallWr && int'(strb.lane) == g) fallMask[g*8 +: 8] <= wrData;
      end
    end
  end

  assign riseHit = sync2[MON_CHAN-1:0] & ~prevIn & riseMask[MON_CHAN-1:0]
                 & {MON_CHAN{ctrlReg[CT_RISE]}};
  assign fallHit = ~sync2[MON_CHAN-1:0] & prevIn & fallMask[MON_CHAN-1:0]
                 & {MON_CHAN{ctrlReg[CT_FALL]}};
  assign anyEdge = |(riseHit | fallHit);
  assign clrEdge = strb.clrWr & wrData[CL_EDGE];
  assign clrOvf  = strb.clrWr & wrData[CL_OVF];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      edgeFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (strb.ctrlWr) ctrlReg <= wrData[CTRL_W-1:0];
      edgeFlag <= (edgeFlag & ~clrEdge) | anyEdge;
      ovfFlag  <= (ovfFlag & ~clrOvf) | (anyEdge & edgeFlag & ~clrEdge);
    end
  end

  assign irqOut = ctrlReg[CT_IRQ] & ((edgeFlag & ctrlReg[CT_EDGE]) |
                                     (ovfFlag & ctrlReg[CT_OVF]));

  logic [IN_LANES*8-1:0]  inPad, inShift;
  logic [MON_LANES*8-1:0] riseShift, fallShift;
  assign inPad     = (IN_LANES*8)'(sync2);
  assign inShift   = inPad >> (8 * strb.lane);
  assign riseShift = riseMask >> (8 * strb.lane);
  assign fallShift = fallMask >> (8 * strb.lane);

  always_comb begin
    unique case (strb.rdSel)
      RD_IN:   rdData = inShift[7:0];
      RD_RISE: rdData = riseShift[7:0];
      RD_FALL: rdData = fallShift[7:0];
      RD_STAT: rdData = {5'b0, irqOut, ovfFlag, edgeFlag};
      RD_CTRL: rdData = 8'(ctrlReg);
      default: rdData = 8'h00;
    endcase
  end

  // R4: the edge flag only rises after a monitored input changed
  assert_edge_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(edgeFlag) |-> $past(sync2[MON_CHAN-1:0] != prevIn));
  // R7: overflow only arises while an edge was already pending
  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(edgeFlag));
  // R8: a clear with no competing edge drops the edge flag
  assert_clear_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrEdge && !anyEdge) |=> !edgeFlag);
  // R9: an interrupt needs the master enable and a pending flag
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ctrlReg[CT_IRQ] && (edgeFlag || ovfFlag)));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_CHAN = 24,
  parameter int MON_CHAN = 16,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CHAN-1:0] chanIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  output logic                irqOut
);
  regStrobe_t strb;

  edge_irq_decode #(.NUM_CHAN(NUM_CHAN), .MON_CHAN(MON_CHAN), .ADDR_W(ADDR_W)) i_decode (
    .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  edge_irq_datapath #(.NUM_CHAN(NUM_CHAN), .MON_CHAN(MON_CHAN)) i_datapath (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .strb(strb),
    .wrData(regWrData), .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] chanIn = '0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        irqOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic drive(input logic [23:0] v);
    @(negedge clk);
    chanIn = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic testReset();
    rdChk("R1 status", 5'h08, 8'h00);
    rdChk("R1 ctrl", 5'h09, 8'h00);
    rdChk("R1 rise0", 5'h10, 8'h00);
    rdChk("R1 fall1", 5'h19, 8'h00);
    check("R1 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testMasks();
    wr(5'h10, 8'hA5); wr(5'h11, 8'h3C); wr(5'h18, 8'h5A); wr(5'h19, 8'hC3);
    wr(5'h12, 8'hFF); wr(5'h1A, 8'hFF);
    rdChk("R2 rise0", 5'h10, 8'hA5);
    rdChk("R2 rise1", 5'h11, 8'h3C);
    rdChk("R2 fall0", 5'h18, 8'h5A);
    rdChk("R2 fall1", 5'h19, 8'hC3);
    rdChk("R3 rise lane2", 5'h12, 8'h00);
    rdChk("R3 fall lane2", 5'h1A, 8'h00);
  endtask

  task automatic testRise();
    wr(5'h10, 8'h01); wr(5'h11, 8'h00); wr(5'h18, 8'h00); wr(5'h19, 8'h00);
    wr(5'h09, 8'h0D);
    drive(24'h000001);
    rdChk("R4 rise sets edge", 5'h08, 8'h05);
    check("R9 irq on edge", {7'b0, irqOut}, 8'h01);
    wr(5'h0A, 8'h0C);
    rdChk("R8 clear both", 5'h08, 8'h00);
    check("R9 irq after clear", {7'b0, irqOut}, 8'h00);
    drive(24'h000000);
    rdChk("R4 fall ignored", 5'h08, 8'h00);
  endtask

  task automatic testFall();
    wr(5'h18, 8'h01); wr(5'h09, 8'h15);
    drive(24'h000001);
    rdChk("R6 rise class off", 5'h08, 8'h00);
    drive(24'h000000);
    rdChk("R5 fall sets edge", 5'h08, 8'h05);
    wr(5'h0A, 8'h0C);
    rdChk("R8 clear after fall", 5'h08, 8'h00);
  endtask

  task automatic testOverflow();
    wr(5'h09, 8'h1F); wr(5'h11, 8'h80);
    drive(24'h008000);
    rdChk("R4 ch15 rise", 5'h08, 8'h05);
    drive(24'h008001);
    rdChk("R7 overflow", 5'h08, 8'h07);
    wr(5'h0A, 8'hF3);
    rdChk("R8 other bits no effect", 5'h08, 8'h07);
    wr(5'h0A, 8'h08);
    rdChk("R8 edge only cleared", 5'h08, 8'h06);
    check("R9 irq from overflow", {7'b0, irqOut}, 8'h01);
    wr(5'h09, 8'h1D);
    rdChk("R9 overflow irq gated", 5'h08, 8'h02);
    check("R9 irq low gated", {7'b0, irqOut}, 8'h00);
    wr(5'h0A, 8'h04);
    rdChk("R8 overflow cleared", 5'h08, 8'h00);
  endtask

  task automatic testUpper();
    wr(5'h09, 8'h1F);
    drive(24'hFF8001);
    rdChk("R3 upper channels ignored", 5'h08, 8'h00);
    rdChk("R10 input lane2", 5'h02, 8'hFF);
    rdChk("R10 input lane1", 5'h01, 8'h80);
    rdChk("R10 input lane0", 5'h00, 8'h01);
    drive(24'h008001);
    rdChk("R3 upper fall ignored", 5'h08, 8'h00);
  endtask

  task automatic testCtrl();
    wr(5'h09, 8'hFF);
    rdChk("R11 ctrl readback", 5'h09, 8'h1F);
    wr(5'h09, 8'h19);
    rdChk("R11 ctrl partial", 5'h09, 8'h19);
    drive(24'h008000);
    rdChk("R9 no master enable", 5'h08, 8'h01);
    check("R9 irq low no enable", {7'b0, irqOut}, 8'h00);
    wr(5'h09, 8'h1D);
    rdChk("R9 master enable", 5'h08, 8'h05);
    check("R9 irq high", {7'b0, irqOut}, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMasks();
    testRise();
    testFall();
    testOverflow();
    testUpper();
    testCtrl();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule